// File: doc/BRIEF.md
# Reset-Qualified Chip-Enable Gate

This block sits in the path of an active-low memory chip-enable between a processor and a battery-backed RAM. While the supervisor holds reset released, the chip-enable passes straight through in the same cycle. While reset is held, the output is forced high (inactive), so a processor running on a failing supply cannot corrupt the RAM. A `gate_en` flag reports whether the gate is currently passing the input.

A write may already be under way when reset arrives. If the chip-enable input is low in the first cycle of reset, the output stays low for at most `GRACE_CYC` cycles, counting that first cycle. The gate then closes. If the input goes high earlier, the gate closes at once, and the window never restarts during that reset. If the input is high when reset arrives, the gate closes in that same cycle. The registers power up as if reset had already been seen. A reset that is present from power-up therefore opens no window.

Top module: `ce_guard`

## Requirements
- R1: While `sup_rst_n` is 1, `ce_out_n` equals `ce_in_n` in the same cycle and `gate_en` is 1.
- R2: While `sup_rst_n` is 0 and no grace window is open, `ce_out_n` is 1 and `gate_en` is 0, whatever `ce_in_n` does.
- R3: If `ce_in_n` is 1 in the first cycle that `sup_rst_n` is 0, `ce_out_n` is 1 and `gate_en` is 0 in that same cycle.
- R4: If `ce_in_n` is 0 in the first cycle that `sup_rst_n` is 0, `ce_out_n` stays 0 (with `gate_en` 1) for as long as `ce_in_n` stays 0, up to `GRACE_CYC` cycles counting the first. After that it is 1.
- R5: Once the output has gone high during a reset, it stays high until reset is released. A rise of `ce_in_n` inside the window closes the gate in that cycle, and a later fall does not reopen it.
- R6: In the first cycle in which `sup_rst_n` returns to 1, pass-through resumes.
- R7: `gate_en` is 0 exactly when the gate is closed, and `ce_out_n` is 1 whenever `gate_en` is 0.
- R8: A reset that is already asserted at power-up opens no grace window, even when `ce_in_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sup_rst_n | input | 1 | Active-low reset from the supply supervisor |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| ce_out_n | output | 1 | Gated active-low chip-enable to the RAM |
| gate_en | output | 1 | 1 while the gate passes `ce_in_n` |

## Verification
Both outputs are combinational in the present inputs and the state held from earlier cycles. A change of `sup_rst_n` or `ce_in_n` therefore shows on `ce_out_n` and `gate_en` in the same cycle, and the grace count advances once per clock edge. The bench drives inputs just after the falling edge and samples the outputs 1 ns later, before the next rising edge. It compares them with a bench model whose state it steps once per cycle. Window length is checked as a count of cycles from the first reset cycle, so a window that is one cycle short or one cycle long is caught.

// File: rtl/ce_guard.sv
module ce_guard #(
  parameter int GRACE_CYC = 6
) (
  input  logic clk,
  input  logic sup_rst_n,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic gate_en
);
  localparam int CW = $clog2(GRACE_CYC + 1);

  logic          in_rst_q = 1'b1;
  logic          hold_q   = 1'b0;
  logic [CW-1:0] used_q   = '0;

  logic          in_rst;
  logic          first_rst;
  logic          hold_now;
  logic [CW-1:0] used_now;

  assign in_rst    = ~sup_rst_n;
  assign first_rst = in_rst & ~in_rst_q;
  assign hold_now  = in_rst & ~ce_in_n & (first_rst | hold_q);
  assign used_now  = first_rst ? CW'(1) : used_q + 1'b1;

  assign gate_en  = sup_rst_n | hold_now;
  assign ce_out_n = gate_en ? ce_in_n : 1'b1;

  always_ff @(posedge clk) begin
    in_rst_q <= in_rst;
    hold_q   <= hold_now & (used_now < CW'(GRACE_CYC));
    used_q   <= hold_now ? used_now : '0;
  end
endmodule

// File: rtl/ce_guard_chk.sv
module ce_guard_chk #(
  parameter int GRACE_CYC = 6
) (
  input logic clk,
  input logic sup_rst_n,
  input logic ce_in_n,
  input logic ce_out_n,
  input logic gate_en
);
  logic        started  = 1'b0;
  logic        prev_rst = 1'b1;
  int unsigned run_q    = 0;
  logic        low_in_rst;

  assign low_in_rst = ~sup_rst_n & ~ce_out_n;

  always_ff @(posedge clk) begin
    started  <= 1'b1;
    prev_rst <= ~sup_rst_n;
    run_q    <= low_in_rst ? run_q + 1 : 0;
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!started)
    sup_rst_n |-> (ce_out_n == ce_in_n) && gate_en);

  a_r3_closed_on_entry: assert property (@(posedge clk) disable iff (!started)
    (!sup_rst_n && !prev_rst && ce_in_n) |-> (ce_out_n && !gate_en));

  a_r4_window_bound: assert property (@(posedge clk) disable iff (!started)
    low_in_rst |-> (run_q < GRACE_CYC));

  a_r5_no_reopen: assert property (@(posedge clk) disable iff (!started)
    (!sup_rst_n && $past(!sup_rst_n) && $past(ce_out_n)) |-> ce_out_n);

  a_r7_flag_closed: assert property (@(posedge clk) disable iff (!started)
    !gate_en |-> ce_out_n);
endmodule

bind ce_guard ce_guard_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (
  .clk(clk), .sup_rst_n(sup_rst_n), .ce_in_n(ce_in_n),
  .ce_out_n(ce_out_n), .gate_en(gate_en)
);

// File: tb/ce_guard_bench.sv
module ce_guard_bench;
  localparam int GRACE = 6;

  logic clk = 1'b0;
  logic sup_rst_n = 1'b0;
  logic ce_in_n = 1'b0;
  logic ce_out_n, gate_en;
  int total = 0, bad = 0;
  bit done = 0;

  bit m_in_rst = 1'b1;
  bit m_hold = 1'b0;
  int m_used = 0;

  always #2.5 clk = ~clk;

  ce_guard #(.GRACE_CYC(GRACE)) u_ce_guard (
    .clk(clk), .sup_rst_n(sup_rst_n), .ce_in_n(ce_in_n),
    .ce_out_n(ce_out_n), .gate_en(gate_en)
  );

  function automatic string req_tag(bit rst_n, bit ce_n, bit prev_rst, bit hold);
    if (rst_n) return prev_rst ? "R6" : "R1";
    if (!prev_rst) return ce_n ? "R3" : "R4";
    if (hold) return ce_n ? "R5" : "R4";
    return "R2";
  endfunction

  task automatic step(input bit rst_n, input bit ce_n);
    bit first, hold_now, exp_out, exp_en;
    int used_now;
    string tag;
    @(negedge clk);
    sup_rst_n = rst_n;
    ce_in_n = ce_n;
    #1;
    first    = !rst_n && !m_in_rst;
    hold_now = !rst_n && !ce_n && (first || m_hold);
    used_now = first ? 1 : m_used + 1;
    exp_en   = rst_n || hold_now;
    exp_out  = exp_en ? ce_n : 1'b1;
    tag = req_tag(rst_n, ce_n, m_in_rst, m_hold || first);
    total++;
    if (ce_out_n !== exp_out || gate_en !== exp_en) begin
      bad++;
      $display("FAIL %s: ce_out_n=%b gate_en=%b expected %b %b", tag, ce_out_n, gate_en, exp_out, exp_en);
    end
    if (!exp_en) begin
      total++;
      if (ce_out_n !== 1'b1) begin
        bad++;
        $display("FAIL R7: ce_out_n=%b expected 1 when closed", ce_out_n);
      end
    end
    m_in_rst = !rst_n;
    m_hold   = hold_now && (used_now < GRACE);
    m_used   = hold_now ? used_now : 0;
  endtask

  initial begin
    int low_run;
    void'($urandom(32'd4117));
    // R8: reset present from power-up with the write strobe low
    step(0, 0);
    step(0, 0);
    step(1, 1);
    step(1, 0);
    // R4: full window
    step(0, 0);
    low_run = 1;
    for (int i = 0; i < GRACE + 2; i++) begin
      step(0, 0);
      if (ce_out_n === 1'b0) low_run++;
    end
    total++;
    if (low_run != GRACE) begin
      bad++;
      $display("FAIL R4: window length=%0d expected %0d", low_run, GRACE);
    end
    // R5: early rise, then fall again, no reopen
    step(1, 0);
    step(0, 0);
    step(0, 0);
    step(0, 1);
    step(0, 0);
    step(0, 0);
    // R3: strobe high on entry
    step(1, 1);
    step(0, 1);
    step(0, 0);
    // R6: release in the middle of a window
    step(1, 0);
    step(0, 0);
    step(0, 0);
    step(1, 0);
    step(1, 1);
    step(1, 0);
    for (int i = 0; i < 3000; i++) begin
      bit r = ($urandom % 8 == 0) ? ~sup_rst_n : sup_rst_n;
      bit c = ($urandom % 4 == 0) ? ~ce_in_n : ce_in_n;
      step(r, c);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule